// File: doc/BRIEF.md
# DS2 Overhead Alarm Monitor

This block watches the overhead bits of a frame-aligned DS2 stream carrying four DS1 tributaries. A synchronizer upstream delivers each stuffing-control bit with its M-subframe number and its position in the subframe, and delivers the X bit once per M-frame. The monitor reports a persistent loopback request for each DS1 tributary and a persistent remote alarm indication (RAI) for the DS2 as a whole.

A tributary carries a loopback request in a frame when the third stuffing-control bit of its M-subframe disagrees with both the first and the second. Each tributary runs its own persistence counter, and so does the X-bit RAI detector. A flag changes state only after an unbroken run of frames that disagree with its current value. When the synchronizer reports loss of frame, all counters freeze and all flags hold their values. Within a chip, tributary `z` (1..4) of DS2 instance `y` is DS1 channel `4*(y-1)+z`. This block reports it on `lb_det[z-1]`.

Top module: `ds2_ovh_alarm_mon`

## Requirements
- R1: After reset, `lb_det` is 4'b0000 and `rai_det` is 0.
- R2: A C-bit frame for subframe `s` is valid when position codes 0, 1 and 2 (first, second, third C bit) arrive on `c_sub == s` in that order while `in_frame` is 1. The frame is a request when the third bit differs from the first and from the second. Five consecutive request frames for that subframe set `lb_det[s]`.
- R3: While `lb_det[s]` is 1, five consecutive non-request frames for subframe `s` clear it.
- R4: A frame that agrees with the current flag value restarts that tributary's run. After a break, a full run of five is needed again.
- R5: Some strobes do not form a frame and leave the flags unchanged: a strobe with position code 3, a second or third C bit that arrives without its predecessors, and a capture that is interrupted by loss of frame.
- R6: While `in_frame` is 0, C-bit and X-bit strobes are ignored. Flags hold their values, and counts made before the loss of frame resume once it ends.
- R7: `rai_det` sets after the X bit is 0 in four consecutive in-frame M-frames.
- R8: Once set, `rai_det` clears only after the X bit is 1 in four consecutive in-frame M-frames. A frame that agrees with the current value restarts the run.
- R9: The four tributaries are independent. Frames on subframe `s` never change `lb_det` for any other subframe.
- R10: A flag changes in the first clock after the edge that samples the strobe completing its run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_frame | input | 1 | Synchronizer reports frame alignment |
| c_vld | input | 1 | C-bit strobe |
| c_sub | input | 2 | M-subframe number minus one (0..3) |
| c_pos | input | 2 | C-bit position: 0 first, 1 second, 2 third, 3 unused |
| c_val | input | 1 | C-bit value |
| x_vld | input | 1 | X-bit strobe, once per M-frame |
| x_val | input | 1 | X-bit value |
| lb_det | output | 4 | Loopback request detected, bit s for subframe s |
| rai_det | output | 1 | Remote alarm indication detected |

## Verification
Each flag is due one clock after the rising edge that samples the third C bit, or the X bit, that completes its run. The bench drives every strobe on a falling edge and holds it for one cycle. It compares all five flags at the next falling edge, after each frame. The sweep sends every 3-bit C pattern five times on each subframe, and an arithmetic run-length model predicts every flag. Further sequences break runs, send malformed or out-of-frame strobes, and step RAI through set, interruption and clear.

// File: rtl/ds2_ovh_pkg.sv
package ds2_ovh_pkg;
  localparam int unsigned NUM_TRIB    = 4;
  localparam int unsigned LB_PERSIST  = 5;
  localparam int unsigned RAI_PERSIST = 4;

  typedef enum logic [1:0] {
    CPOS_FIRST  = 2'd0,
    CPOS_SECOND = 2'd1,
    CPOS_THIRD  = 2'd2,
    CPOS_UNUSED = 2'd3
  } cpos_e;
endpackage

// File: rtl/ds2_persist_flag.sv
module ds2_persist_flag #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic obs,
  output logic flag
);
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (evt) begin
      if (obs != flag_q) begin
        if (cnt_q == LAST) begin
          flag_d = obs;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (evt) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  a_r6_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> (flag_q == $past(flag_q) && cnt_q == $past(cnt_q)));

  a_r10_flip_needs_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != $past(flag_q)) |-> ($past(evt) && $past(cnt_q) == LAST));
endmodule

// File: rtl/ds2_cbit_capture.sv
module ds2_cbit_capture
  import ds2_ovh_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_frame,
  input  logic  stb,
  input  cpos_e pos,
  input  logic  val,
  output logic  frame_evt,
  output logic  req
);
  logic       c1_q, c1_d;
  logic       c2_q, c2_d;
  logic [1:0] got_q, got_d;

  always_comb begin
    c1_d  = c1_q;
    c2_d  = c2_q;
    got_d = got_q;
    if (!in_frame) begin
      got_d = 2'b00;
    end else if (stb) begin
      unique case (pos)
        CPOS_FIRST:  begin c1_d = val; got_d = 2'b01; end
        CPOS_SECOND: begin
          if (got_q == 2'b01) begin c2_d = val; got_d = 2'b11; end
          else                got_d = 2'b00;
        end
        CPOS_THIRD:  got_d = 2'b00;
        default:     got_d = got_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q  <= 1'b0;
      c2_q  <= 1'b0;
      got_q <= 2'b00;
    end else begin
      c1_q  <= c1_d;
      c2_q  <= c2_d;
      got_q <= got_d;
    end
  end

  assign frame_evt = in_frame && stb && (pos == CPOS_THIRD) && (got_q == 2'b11);
  assign req       = (val != c1_q) && (val != c2_q);

  a_r5_capture_cleared_when_oof: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |=> (got_q == 2'b00));
endmodule

// File: rtl/ds2_ovh_alarm_mon.sv
module ds2_ovh_alarm_mon
  import ds2_ovh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_frame,
  input  logic       c_vld,
  input  logic [1:0] c_sub,
  input  logic [1:0] c_pos,
  input  logic       c_val,
  input  logic       x_vld,
  input  logic       x_val,
  output logic [3:0] lb_det,
  output logic       rai_det
);
  logic [NUM_TRIB-1:0] trib_evt;
  logic [NUM_TRIB-1:0] trib_req;

  for (genvar s = 0; s < NUM_TRIB; s++) begin : g_trib
    logic trib_stb;
    assign trib_stb = c_vld && (c_sub == 2'(s));

    ds2_cbit_capture u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_frame  (in_frame),
      .stb       (trib_stb),
      .pos       (cpos_e'(c_pos)),
      .val       (c_val),
      .frame_evt (trib_evt[s]),
      .req       (trib_req[s])
    );

    ds2_persist_flag #(.RUN_LEN(LB_PERSIST)) u_lb (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (trib_evt[s]),
      .obs   (trib_req[s]),
      .flag  (lb_det[s])
    );

    a_r9_only_addressed_trib: assert property (@(posedge clk) disable iff (!rst_n)
      !(c_vld && c_sub == 2'(s)) |=> (lb_det[s] == $past(lb_det[s])));
  end

  logic x_evt;
  assign x_evt = x_vld && in_frame;

  ds2_persist_flag #(.RUN_LEN(RAI_PERSIST)) u_rai (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (x_evt),
    .obs   (~x_val),
    .flag  (rai_det)
  );

  a_r6_oof_freezes_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |=> (lb_det == $past(lb_det) && rai_det == $past(rai_det)));

  a_r5_unused_pos_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vld && c_pos == 2'd3) |=> (lb_det == $past(lb_det)));

  a_r8_rai_moves_only_on_x: assert property (@(posedge clk) disable iff (!rst_n)
    !x_vld |=> (rai_det == $past(rai_det)));

  a_r9_one_trib_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lb_det ^ $past(lb_det)) <= 1);
endmodule

// File: tb/ds2_ovh_alarm_mon_bench.sv
module ds2_ovh_alarm_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_frame = 1'b0;
  logic       c_vld = 1'b0;
  logic [1:0] c_sub = 2'd0;
  logic [1:0] c_pos = 2'd0;
  logic       c_val = 1'b0;
  logic       x_vld = 1'b0;
  logic       x_val = 1'b0;
  logic [3:0] lb_det;
  logic       rai_det;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] m_lb = 4'b0;
  int         m_run [4] = '{0, 0, 0, 0};
  logic       m_rai = 1'b0;
  int         m_xrun = 0;

  always #2 clk = ~clk;

  ds2_ovh_alarm_mon u_ds2_ovh_alarm_mon (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame),
    .c_vld(c_vld), .c_sub(c_sub), .c_pos(c_pos), .c_val(c_val),
    .x_vld(x_vld), .x_val(x_val), .lb_det(lb_det), .rai_det(rai_det)
  );

  task automatic check(input string tag);
    n_chk++;
    if (lb_det !== m_lb || rai_det !== m_rai) begin
      n_bad++;
      $display("FAIL %s: lb_det=%b rai_det=%b expected lb_det=%b rai_det=%b",
               tag, lb_det, rai_det, m_lb, m_rai);
    end
  endtask

  task automatic strobe_c(input int s, input int pos, input logic v);
    @(negedge clk);
    c_vld = 1'b1; c_sub = 2'(s); c_pos = 2'(pos); c_val = v;
    @(negedge clk);
    c_vld = 1'b0;
  endtask

  // Model: a counted frame that disagrees with the flag extends the run.
  // A frame that agrees with the flag restarts the run.
  task automatic model_lb(input int s, input logic req);
    if (req != m_lb[s]) begin
      m_run[s]++;
      if (m_run[s] == 5) begin m_lb[s] = req; m_run[s] = 0; end
    end else m_run[s] = 0;
  endtask

  task automatic frame(input int s, input logic a, input logic b, input logic c,
                       input string tag);
    strobe_c(s, 0, a);
    strobe_c(s, 1, b);
    strobe_c(s, 2, c);
    if (in_frame) model_lb(s, (c != a) && (c != b));
    check(tag);
  endtask

  task automatic xbit(input logic v, input string tag);
    @(negedge clk);
    x_vld = 1'b1; x_val = v;
    @(negedge clk);
    x_vld = 1'b0;
    if (in_frame) begin
      if (!v != m_rai) begin
        m_xrun++;
        if (m_xrun == 4) begin m_rai = !v; m_xrun = 0; end
      end else m_xrun = 0;
    end
    check(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    in_frame = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2 R3 R9 R10: every C pattern five times on every subframe.
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 8; p++)
        for (int k = 0; k < 5; k++)
          frame(s, p[2], p[1], p[0], "R2/R3/R9/R10 sweep");

    // R4: a break in the run restarts the count.
    for (int k = 0; k < 4; k++) frame(1, 0, 0, 1, "R4 pre-break");
    frame(1, 0, 1, 1, "R4 break frame");
    for (int k = 0; k < 5; k++) frame(1, 1, 1, 0, "R4 rerun");
    for (int k = 0; k < 4; k++) frame(1, 0, 0, 0, "R4 clear pre-break");
    frame(1, 1, 1, 0, "R4 clear break");
    for (int k = 0; k < 5; k++) frame(1, 1, 1, 1, "R4 clear rerun");

    // R5: malformed sequences never count.
    for (int k = 0; k < 6; k++) begin
      strobe_c(2, 0, 0); strobe_c(2, 2, 1); check("R5 missing second");
      strobe_c(2, 1, 0); strobe_c(2, 2, 1); check("R5 missing first");
      strobe_c(2, 3, 1); check("R5 unused position");
    end
    for (int k = 0; k < 6; k++) begin
      strobe_c(2, 0, 0); strobe_c(2, 1, 0);
      @(negedge clk); in_frame = 1'b0;
      @(negedge clk); in_frame = 1'b1;
      strobe_c(2, 2, 1); check("R5 interrupted capture");
    end

    // R6: counts freeze and resume across loss of frame.
    for (int k = 0; k < 3; k++) frame(3, 1, 1, 0, "R6 before oof");
    in_frame = 1'b0;
    for (int k = 0; k < 6; k++) frame(3, 1, 1, 0, "R6 during oof");
    for (int k = 0; k < 5; k++) xbit(1'b0, "R6 x during oof");
    in_frame = 1'b1;
    frame(3, 1, 1, 0, "R6 resume 4th");
    frame(3, 1, 1, 0, "R6 resume 5th sets");

    // R7 R8: RAI set, interrupted runs, clear.
    for (int k = 0; k < 3; k++) xbit(1'b0, "R7 pre-break");
    xbit(1'b1, "R7 break");
    for (int k = 0; k < 4; k++) xbit(1'b0, "R7 set run");
    for (int k = 0; k < 3; k++) xbit(1'b1, "R8 pre-break");
    xbit(1'b0, "R8 break");
    for (int k = 0; k < 4; k++) xbit(1'b1, "R8 clear run");
    for (int k = 0; k < 2; k++) xbit(1'b0, "R8 tail");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule